// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Model

This block is a synthesizable stand-in for a byte-wide, ultraviolet-erasable programmable read-only memory. Other logic can then talk to it exactly as it would talk to the real part. Two active-low controls steer it: `cs_n` selects the device and also carries the program strobe, and `rd_n` gates the output. Two digital flags stand in for the high-voltage conditions of the real device. `vprog` marks that the programming supply is present, and `idmode` marks that the identifier pin is raised. The block decodes these four inputs into seven modes: read, standby, output disable, program, program verify, program inhibit and identifier read.

The tri-stated bus is split into an input byte, an output byte and an output enable. A chip-level pad or bus multiplexer joins them. A write can only clear bits: the stored byte becomes the old byte ANDed with the byte presented. A synchronous `wipe` input takes the place of ultraviolet erasure and returns every cell to all ones. The model has no analog timing. Instead, a strobe on `cs_n` counts as a valid program pulse only if it stays low for no more than `MAX_PULSE` clock cycles.

Top module: `otp_byte_mem`

## Requirements
- R1: With `vprog`=0, `idmode`=0, `cs_n`=0 and `rd_n`=0 (read), `dq_oe`=1 and `dq_o` equals the byte stored at `addr`, in the same cycle.
- R2: With `cs_n`=1 and `vprog`=0 (standby), `dq_oe`=0 whatever `rd_n` is.
- R3: With `cs_n`=0, `rd_n`=1 and `vprog`=0 (output disable), `dq_oe`=0.
- R4: A program pulse leaves the addressed byte equal to its old value ANDed with `dq_i`. No bit ever changes from 0 to 1 through programming.
- R5: Program mode is `vprog`=1, `cs_n`=0, `rd_n`=1. The write takes effect at the first clock edge that sees `cs_n` high again after the pulse, using the address and data held during the pulse.
- R6: With `vprog`=1 and `cs_n`=1 (inhibit), the array is unchanged and `dq_oe`=0.
- R7: With `vprog`=1, `cs_n`=0 and `rd_n`=0 (verify), `dq_oe`=1 and `dq_o` is the stored byte at `addr`.
- R8: With `vprog`=0, `idmode`=1, `cs_n`=0 and `rd_n`=0, `dq_o` is 0x8F when `addr[0]`=0 and 0x85 when `addr[0]`=1.
- R9: A pulse that holds `cs_n` low for more than `MAX_PULSE` clock edges is ignored. A pulse of exactly `MAX_PULSE` edges is accepted.
- R10: In program mode `dq_oe`=0, so the bus is left to the data source.
- R11: A pulse is dropped if program mode is left while `cs_n` is still low, for example when `vprog` falls.
- R12: `wipe`=1 at a clock edge sets every byte to 0xFF. While reset is active, `dq_oe` is 0 in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wipe | input | 1 | Synchronous erase of the whole array to 0xFF |
| addr | input | AW | Byte address |
| dq_i | input | 8 | Data presented for programming |
| dq_o | output | 8 | Data driven to the bus |
| dq_oe | output | 1 | Bus drive enable |
| cs_n | input | 1 | Chip select and program strobe, active low |
| rd_n | input | 1 | Output enable, active low |
| vprog | input | 1 | Programming supply present |
| idmode | input | 1 | Identifier pin raised |

## Verification
Reads, verify, identifier reads and the bus enable come straight from the inputs through combinational logic. They are due in the same cycle, so the bench changes the inputs on a falling edge and samples one time unit later, before the next rising edge. A program or wipe takes effect at the first rising edge after `cs_n` returns high or after `wipe` is sampled. The bench therefore reads the result back only on the following falling edge. Pulse length is counted in rising edges that see `cs_n` low, and this is how the accepted pulse of exactly `MAX_PULSE` edges and the ignored pulse of one edge more are set up.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    M_STANDBY, M_READ, M_OUTDIS, M_IDENT, M_PROG, M_VERIFY, M_INHIBIT
  } otp_mode_e;
  localparam logic [7:0] MFG_CODE = 8'h8F;
  localparam logic [7:0] DEV_CODE = 8'h85;
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
(
  input  logic      cs_n,
  input  logic      rd_n,
  input  logic      vprog,
  input  logic      idmode,
  output otp_mode_e mode,
  output logic      drive,
  output logic      sel_id
);
  always_comb begin
    if (vprog) begin
      if (cs_n)      mode = M_INHIBIT;
      else if (rd_n) mode = M_PROG;
      else           mode = M_VERIFY;
    end else begin
      if (cs_n)        mode = M_STANDBY;
      else if (rd_n)   mode = M_OUTDIS;
      else if (idmode) mode = M_IDENT;
      else             mode = M_READ;
    end
  end

  assign drive  = (mode == M_READ) || (mode == M_VERIFY) || (mode == M_IDENT);
  assign sel_id = (mode == M_IDENT);
endmodule

// File: rtl/otp_pulse_trk.sv
module otp_pulse_trk
  import otp_pkg::*;
#(
  parameter int AW        = 4,
  parameter int MAX_PULSE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  otp_mode_e     mode,
  input  logic          cs_n,
  input  logic          vprog,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          commit,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata
);
  localparam int CW = $clog2(MAX_PULSE + 2);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_PULSE);
  localparam logic [CW-1:0] CNT_SAT = CW'(MAX_PULSE + 1);

  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] a_q, a_d;
  logic [7:0]    d_q, d_d;
  logic          cap_en;

  assign cap_en = (mode == M_PROG);

  always_comb begin
    act_d = 1'b0;
    cnt_d = '0;
    a_d   = a_q;
    d_d   = d_q;
    if (cap_en) begin
      act_d = 1'b1;
      cnt_d = (cnt_q == CNT_SAT) ? CNT_SAT : cnt_q + 1'b1;
      a_d   = addr;
      d_d   = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      a_q   <= '0;
      d_q   <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      a_q   <= a_d;
      d_q   <= d_d;
    end
  end

  assign commit = act_q && cs_n && vprog && (cnt_q <= CNT_MAX);
  assign waddr  = a_q;
  assign wdata  = d_q;

  p_commit_after_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(!cs_n && vprog));
  p_long_pulse_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (cnt_q != CNT_SAT));
endmodule

// File: rtl/otp_array.sv
module otp_array #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe,
  input  logic          wr_en,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic cell_we;
    assign cell_we = wr_en && (waddr == AW'(i));
    always_ff @(posedge clk) begin
      if (wipe)         mem_q[i] <= 8'hFF;
      else if (cell_we) mem_q[i] <= mem_q[i] & wdata;
    end
  end

  assign rdata = mem_q[raddr];

  p_clear_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wipe) |=> ((mem_q[$past(waddr)] & ~$past(mem_q[waddr])) == 8'h00));
  p_wipe_all_ones_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (rdata == 8'hFF));
endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
  import otp_pkg::*;
#(
  parameter int AW        = 4,
  parameter int MAX_PULSE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dq_i,
  output logic [7:0]    dq_o,
  output logic          dq_oe,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          vprog,
  input  logic          idmode
);
  logic          rs_q1, rs_q2;
  otp_mode_e     mode;
  logic          drive, sel_id, commit;
  logic [AW-1:0] waddr;
  logic [7:0]    wdata, rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  otp_mode_dec u_dec (
    .cs_n(cs_n), .rd_n(rd_n), .vprog(vprog), .idmode(idmode),
    .mode(mode), .drive(drive), .sel_id(sel_id)
  );

  otp_pulse_trk #(.AW(AW), .MAX_PULSE(MAX_PULSE)) u_trk (
    .clk(clk), .rst_n(rs_q2), .mode(mode), .cs_n(cs_n), .vprog(vprog),
    .addr(addr), .din(dq_i), .commit(commit), .waddr(waddr), .wdata(wdata)
  );

  otp_array #(.AW(AW)) u_arr (
    .clk(clk), .rst_n(rs_q2), .wipe(wipe), .wr_en(commit),
    .waddr(waddr), .wdata(wdata), .raddr(addr), .rdata(rdata)
  );

  assign dq_oe = drive;
  assign dq_o  = sel_id ? (addr[0] ? DEV_CODE : MFG_CODE) : rdata;

  p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rs_q2)
    (cs_n && !vprog) |-> !dq_oe);
  p_outdis_quiet_r3: assert property (@(posedge clk) disable iff (!rs_q2)
    (!cs_n && rd_n && !vprog) |-> !dq_oe);
  p_bus_free_prog_r10: assert property (@(posedge clk) disable iff (!rs_q2)
    (vprog && rd_n) |-> !dq_oe);
  p_ident_code_r8: assert property (@(posedge clk) disable iff (!rs_q2)
    (!vprog && idmode && !cs_n && !rd_n) |-> (dq_o == 8'h8F || dq_o == 8'h85));
endmodule

// File: tb/otp_byte_mem_test.sv
module otp_byte_mem_test;
  localparam int AW = 4;
  localparam int MAXP = 8;

  logic clk = 1'b0;
  logic rst_n, wipe, cs_n, rd_n, vprog, idmode;
  logic [AW-1:0] addr;
  logic [7:0] dq_i, dq_o;
  logic dq_oe;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  otp_byte_mem #(.AW(AW), .MAX_PULSE(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .wipe(wipe), .addr(addr), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe(dq_oe), .cs_n(cs_n), .rd_n(rd_n),
    .vprog(vprog), .idmode(idmode)
  );

  // vector: cs_n, rd_n, vprog, idmode, addr[3:0], exp_oe, exp_data[7:0]
  localparam int NV = 11;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b1, 8'h24},  // R1 R4
    {1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0, 8'h00},  // R2
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd3, 1'b0, 8'h00},  // R2
    {1'b0, 1'b1, 1'b0, 1'b0, 4'd3, 1'b0, 8'h00},  // R3
    {1'b0, 1'b0, 1'b1, 1'b0, 4'd5, 1'b1, 8'h0F},  // R7 R9
    {1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b1, 8'h8F},  // R8
    {1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 8'h85},  // R8
    {1'b0, 1'b1, 1'b1, 1'b0, 4'd2, 1'b0, 8'h00},  // R10
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd6, 1'b1, 8'hFF},  // R9
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd7, 1'b1, 8'hFF},  // R11
    {1'b1, 1'b0, 1'b1, 1'b0, 4'd3, 1'b0, 8'h00}   // R6
  };

  task automatic chk(input string req, input logic oe_e, input logic [7:0] d_e);
    checks++;
    if (dq_oe !== oe_e || (oe_e && dq_o !== d_e)) begin
      fails++;
      $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h",
               req, dq_oe, dq_o, oe_e, d_e);
    end
  endtask

  task automatic pulse(input logic [AW-1:0] a, input logic [7:0] d, input int len);
    @(negedge clk);
    vprog = 1'b1; rd_n = 1'b1; cs_n = 1'b1; addr = a; dq_i = d;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (len) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    vprog = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    vprog = 1'b0; idmode = 1'b0; cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1;
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wipe = 1'b0; cs_n = 1'b1; rd_n = 1'b1; vprog = 1'b0;
    idmode = 1'b0; addr = '0; dq_i = '0;
    repeat (3) @(negedge clk);
    #1 chk("R12 reset", 1'b0, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    wipe = 1'b1;
    @(negedge clk) wipe = 1'b0;
    rd(4'd9); chk("R12 wipe", 1'b1, 8'hFF);
    @(negedge clk) cs_n = 1'b1; rd_n = 1'b1;

    pulse(4'd3, 8'hA5, 1);
    rd(4'd3); chk("R5 first write", 1'b1, 8'hA5);
    @(negedge clk) cs_n = 1'b1;
    pulse(4'd3, 8'h3C, 2);                 // R4: A5 & 3C = 24
    pulse(4'd5, 8'h0F, MAXP);              // R9 exact limit accepted
    pulse(4'd6, 8'h00, MAXP + 1);          // R9 too long, ignored
    // R11: vprog drops mid-pulse on address 7
    @(negedge clk) vprog = 1'b1; rd_n = 1'b1; addr = 4'd7; dq_i = 8'h00;
    @(negedge clk) cs_n = 1'b0;
    repeat (3) @(negedge clk);
    vprog = 1'b0;
    @(negedge clk) cs_n = 1'b1; vprog = 1'b1;
    @(negedge clk) vprog = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {cs_n, rd_n, vprog, idmode, addr} = VEC[i][16:9];
      #1 chk($sformatf("R1-vec%0d", i), VEC[i][8], VEC[i][7:0]);
      @(negedge clk);
      #1 chk($sformatf("R2-vec%0d hold", i), VEC[i][8], VEC[i][7:0]);
    end

    // R6: hold inhibit with zero data, array must keep 24
    @(negedge clk) vprog = 1'b1; cs_n = 1'b1; rd_n = 1'b1; addr = 4'd3; dq_i = 8'h00;
    repeat (5) @(negedge clk);
    vprog = 1'b0;
    rd(4'd3); chk("R6 inhibit keeps byte", 1'b1, 8'h24);
    // R4: ones presented cannot set cleared bits
    @(negedge clk) cs_n = 1'b1;
    pulse(4'd3, 8'hFF, 1);
    rd(4'd3); chk("R4 no 0-to-1", 1'b1, 8'h24);
    // R7 verify right after a write
    @(negedge clk) cs_n = 1'b1;
    pulse(4'd4, 8'h5A, 3);
    @(negedge clk) vprog = 1'b1; cs_n = 1'b0; rd_n = 1'b0; addr = 4'd4;
    #1 chk("R7 verify", 1'b1, 8'h5A);
    @(negedge clk) cs_n = 1'b1; vprog = 1'b0;
    @(negedge clk) wipe = 1'b1;
    @(negedge clk) wipe = 1'b0;
    rd(4'd3); chk("R12 wipe after program", 1'b1, 8'hFF);
    rd(4'd4); chk("R12 wipe second byte", 1'b1, 8'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule